// File: doc/BRIEF.md
# Oscillator Phase Sync Sequencer

This block takes a pending phase-alignment request for six oscillator voices, three on each of two sound chips, and turns it into an ordered stream of register-write jobs. Each job names a target (left chip, right chip or both), a 5-bit register address and a data byte. A downstream serializer performs the write and acknowledges the job. The voice control-register images live in a register file shared with the rest of the engine. The sequencer reads those images, edits them and writes them back through a single-port interface with combinational read data.

The sequence runs in one of two modes. Lead mode produces a fixed phase offset between the three voices. It first parks every oscillator at maximum frequency, then releases the control writes for voices 1, 2 and 3 with a programmable delay between them. Individual mode restarts only the requested voices, and it issues their control writes back to back. When the sequence ends, the block pulses a clear for the request mask. In lead mode it also pulses a request for a full register rescan, because the frequency registers were overwritten.

States: `ST_IDLE` waits for a non-zero mask. `ST_FREQ` issues the six frequency jobs (lead mode only). `ST_EDIT` rewrites the six control images. `ST_FETCH_L` and `ST_FETCH_R` load the left and right image of the current voice. `ST_SEND_A` issues the dual or left write and `ST_SEND_B` issues the right write. `ST_HOLD` runs the inter-voice delay (lead mode only). `ST_DONE` raises the completion pulses.

Transitions:
- IDLE→FREQ on a request in lead mode, and IDLE→EDIT on a request in individual mode.
- FREQ→EDIT after the sixth acknowledge, and EDIT→FETCH_L after the sixth image.
- FETCH_L→FETCH_R→SEND_A.
- SEND_A→SEND_B when the two images differ.
- After the last write of a voice, the next state is HOLD in lead mode, FETCH_L in individual mode, or DONE after voice 3.
- HOLD→FETCH_L when the timer expires, and DONE→IDLE.

Top module: `psync_seq`

## Requirements
- R1: After reset, and while the request mask is zero, no job is presented, the register file is not written, and neither completion pulse is raised.
- R2: The engine field is latched when a request is accepted. A value of 0 selects lead mode, and any other value (1, 2 or 3) selects individual mode, which issues no frequency jobs.
- R3: Lead mode begins with six dual-chip jobs (target code 2'b11) carrying data 0xFF. The addresses are 0, 1, 7, 8, 14 and 15, which are frequency low then high for voices 1, 2 and 3 (voice stride 7).
- R4: Lead mode clears bit 3 (test) of all six control images and sets bit 0 (gate) only where the mask bit is set; other bits are kept. Mask bits 0–2 are left voices 1–3 and bits 3–5 are right voices 1–3. Register-file index equals mask bit index.
- R5: Individual mode clears bit 3 and sets bit 0 only in the images whose mask bit is set, and leaves every other image unwritten.
- R6: Control writes go out for voice 1, 2, then 3 at addresses 4, 11 and 18. When a voice's left and right images are equal, one dual job (2'b11) is issued. Otherwise a left job (2'b01) is followed by a right job (2'b10).
- R7: In lead mode, after the acknowledge of the final job of voice 1 or voice 2, the next job appears D×CLK_PER_US+3 cycles later, where D = phase_ofs + 14.
- R8: When phase_ofs + 14 exceeds 255, D saturates at 255.
- R9: In individual mode, the next voice's job appears 3 cycles after the previous voice's final acknowledge, with no delay inserted.
- R10: A presented job holds its address, data and target unchanged until acknowledged, and the next job of the same voice follows 1 cycle after an acknowledge.
- R11: At completion, `req_clr` pulses for one cycle. `rescan_req` pulses with it only in lead mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req | input | 6 | Pending request mask, one bit per voice |
| engine_sel | input | 2 | Engine field; 0 = lead mode |
| phase_ofs | input | 8 | Inter-voice offset in microseconds |
| job_valid | output | 1 | A write job is presented |
| job_target | output | 2 | Bit 0 left chip, bit 1 right chip |
| job_addr | output | 5 | Chip register address |
| job_data | output | 8 | Byte to write |
| job_ack | input | 1 | Job accepted at this edge |
| rf_addr | output | 3 | Control-image index (chip×3 + voice) |
| rf_rdata | input | 8 | Image read data, combinational |
| rf_we | output | 1 | Image write strobe |
| rf_wdata | output | 8 | Edited image |
| req_clr | output | 1 | Clear the request mask |
| rescan_req | output | 1 | Request a full register rescan |

## Verification
The directed runs target the split-versus-dual decision of each voice. A design that compared the wrong images would merge unequal left/right values into one dual write, or split equal ones, and either error changes the job count. The delay is measured to the exact cycle at offsets 0, 100 and 250. An off-by-one in the compensation term, a missing saturation or a timer started before the acknowledge each shifts the measured gap. Individual-mode runs with non-zero engine codes check that unrequested images keep their bytes and that no frequency jobs or rescan pulse appear.

// File: rtl/psync_pkg.sv
`timescale 1ns/1ps
package psync_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FREQ,
        ST_EDIT,
        ST_FETCH_L,
        ST_FETCH_R,
        ST_SEND_A,
        ST_SEND_B,
        ST_HOLD,
        ST_DONE
    } psync_state_t;

    localparam logic [1:0] TGT_LEFT  = 2'b01;
    localparam logic [1:0] TGT_RIGHT = 2'b10;
    localparam logic [1:0] TGT_BOTH  = 2'b11;

endpackage

// File: rtl/psync_delay_calc.sv
`timescale 1ns/1ps
module psync_delay_calc #(
    parameter int OFS_W      = 8,
    parameter int COMP_US    = 14,
    parameter int CLK_PER_US = 200,
    parameter int CNT_W      = 16
) (
    input  logic [OFS_W-1:0] phase_ofs,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [OFS_W:0] COMP_EXT = (OFS_W+1)'(COMP_US);

    logic [OFS_W:0]   sum_ext;
    logic [OFS_W-1:0] delay_us;

    always_comb begin
        sum_ext  = {1'b0, phase_ofs} + COMP_EXT;
        delay_us = sum_ext[OFS_W] ? '1 : sum_ext[OFS_W-1:0];
        load_val = CNT_W'(delay_us) * CNT_W'(CLK_PER_US) - CNT_W'(1);
    end
endmodule

// File: rtl/psync_wait_timer.sv
`timescale 1ns/1ps
module psync_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/psync_ctrl_edit.sv
`timescale 1ns/1ps
module psync_ctrl_edit #(
    parameter int DATA_W   = 8,
    parameter int TEST_BIT = 3,
    parameter int GATE_BIT = 0
) (
    input  logic [DATA_W-1:0] img_in,
    input  logic              lead_mode,
    input  logic              voice_req,
    output logic [DATA_W-1:0] img_out,
    output logic              touch
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == TEST_BIT) begin : g_test
            assign img_out[b] = 1'b0;
        end else if (b == GATE_BIT) begin : g_gate
            assign img_out[b] = img_in[b] | voice_req;
        end else begin : g_keep
            assign img_out[b] = img_in[b];
        end
    end

    assign touch = lead_mode | voice_req;
endmodule

// File: rtl/psync_seq.sv
`timescale 1ns/1ps
module psync_seq
    import psync_pkg::*;
#(
    parameter int VOICES       = 3,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int OFS_W        = 8,
    parameter int VOICE_STRIDE = 7,
    parameter int CTRL_OFS     = 4,
    parameter int TEST_BIT     = 3,
    parameter int GATE_BIT     = 0,
    parameter int COMP_US      = 14,
    parameter int CLK_PER_US   = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*VOICES-1:0]           sync_req,
    input  logic [1:0]                    engine_sel,
    input  logic [OFS_W-1:0]              phase_ofs,
    output logic                          job_valid,
    output logic [1:0]                    job_target,
    output logic [ADDR_W-1:0]             job_addr,
    output logic [DATA_W-1:0]             job_data,
    input  logic                          job_ack,
    output logic [$clog2(2*VOICES)-1:0]   rf_addr,
    input  logic [DATA_W-1:0]             rf_rdata,
    output logic                          rf_we,
    output logic [DATA_W-1:0]             rf_wdata,
    output logic                          req_clr,
    output logic                          rescan_req
);
    localparam int MASK_W    = 2 * VOICES;
    localparam int IDX_W     = $clog2(MASK_W);
    localparam int VOICE_W   = (VOICES > 1) ? $clog2(VOICES) : 1;
    localparam int FREQ_JOBS = 2 * VOICES;
    localparam int CNT_W     = $clog2(((1 << OFS_W) - 1) * CLK_PER_US + 1);
    localparam logic [DATA_W-1:0] FREQ_FILL = '1;

    psync_state_t state_q, state_d;

    logic [MASK_W-1:0]  mask_q;
    logic               lead_q;
    logic [OFS_W-1:0]   ofs_q;
    logic [IDX_W-1:0]   idx_q;
    logic [VOICE_W-1:0] voice_q;
    logic [DATA_W-1:0]  img_l_q;
    logic [DATA_W-1:0]  img_r_q;

    logic               images_equal;
    logic               voice_last;
    logic               idx_last_freq;
    logic               idx_last_edit;
    logic               voice_finished;
    logic               timer_load;
    logic               timer_expired;
    logic [CNT_W-1:0]   timer_val;
    logic               edit_req_bit;
    logic [DATA_W-1:0]  edit_img;
    logic               edit_touch;

    assign images_equal  = (img_l_q == img_r_q);
    assign voice_last    = (voice_q == VOICE_W'(VOICES - 1));
    assign idx_last_freq = (idx_q == IDX_W'(FREQ_JOBS - 1));
    assign idx_last_edit = (idx_q == IDX_W'(MASK_W - 1));
    assign edit_req_bit  = ((mask_q >> idx_q) & MASK_W'(1)) != '0;

    assign voice_finished = job_ack &&
        (((state_q == ST_SEND_A) && images_equal) || (state_q == ST_SEND_B));
    assign timer_load = voice_finished && !voice_last && lead_q;

    psync_delay_calc #(
        .OFS_W     (OFS_W),
        .COMP_US   (COMP_US),
        .CLK_PER_US(CLK_PER_US),
        .CNT_W     (CNT_W)
    ) u_delay (
        .phase_ofs(ofs_q),
        .load_val (timer_val)
    );

    psync_wait_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(timer_val),
        .expired (timer_expired)
    );

    psync_ctrl_edit #(
        .DATA_W  (DATA_W),
        .TEST_BIT(TEST_BIT),
        .GATE_BIT(GATE_BIT)
    ) u_edit (
        .img_in   (rf_rdata),
        .lead_mode(lead_q),
        .voice_req(edit_req_bit),
        .img_out  (edit_img),
        .touch    (edit_touch)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_req != '0) begin
                    state_d = (engine_sel == 2'd0) ? ST_FREQ : ST_EDIT;
                end
            end
            ST_FREQ: begin
                if (job_ack && idx_last_freq) begin
                    state_d = ST_EDIT;
                end
            end
            ST_EDIT: begin
                if (idx_last_edit) begin
                    state_d = ST_FETCH_L;
                end
            end
            ST_FETCH_L: state_d = ST_FETCH_R;
            ST_FETCH_R: state_d = ST_SEND_A;
            ST_SEND_A, ST_SEND_B: begin
                if (job_ack) begin
                    if ((state_q == ST_SEND_A) && !images_equal) begin
                        state_d = ST_SEND_B;
                    end else if (voice_last) begin
                        state_d = ST_DONE;
                    end else if (lead_q) begin
                        state_d = ST_HOLD;
                    end else begin
                        state_d = ST_FETCH_L;
                    end
                end
            end
            ST_HOLD: begin
                if (timer_expired) begin
                    state_d = ST_FETCH_L;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequence context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            lead_q  <= 1'b0;
            ofs_q   <= '0;
            idx_q   <= '0;
            voice_q <= '0;
            img_l_q <= '0;
            img_r_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sync_req != '0) begin
                        mask_q  <= sync_req;
                        lead_q  <= (engine_sel == 2'd0);
                        ofs_q   <= phase_ofs;
                        idx_q   <= '0;
                        voice_q <= '0;
                    end
                end
                ST_FREQ: begin
                    if (job_ack) begin
                        idx_q <= idx_last_freq ? '0 : idx_q + IDX_W'(1);
                    end
                end
                ST_EDIT: begin
                    idx_q <= idx_last_edit ? '0 : idx_q + IDX_W'(1);
                end
                ST_FETCH_L: img_l_q <= rf_rdata;
                ST_FETCH_R: img_r_q <= rf_rdata;
                ST_SEND_A, ST_SEND_B: begin
                    if (voice_finished && !voice_last) begin
                        voice_q <= voice_q + VOICE_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        job_valid  = 1'b0;
        job_target = TGT_BOTH;
        job_addr   = '0;
        job_data   = '0;
        rf_addr    = '0;
        rf_we      = 1'b0;
        rf_wdata   = '0;
        req_clr    = 1'b0;
        rescan_req = 1'b0;
        unique case (state_q)
            ST_FREQ: begin
                job_valid  = 1'b1;
                job_target = TGT_BOTH;
                job_addr   = ADDR_W'(idx_q >> 1) * ADDR_W'(VOICE_STRIDE)
                           + ADDR_W'(idx_q[0]);
                job_data   = FREQ_FILL;
            end
            ST_EDIT: begin
                rf_addr  = idx_q;
                rf_we    = edit_touch;
                rf_wdata = edit_img;
            end
            ST_FETCH_L: rf_addr = IDX_W'(voice_q);
            ST_FETCH_R: rf_addr = IDX_W'(VOICES) + IDX_W'(voice_q);
            ST_SEND_A: begin
                job_valid  = 1'b1;
                job_target = images_equal ? TGT_BOTH : TGT_LEFT;
                job_addr   = ADDR_W'(voice_q) * ADDR_W'(VOICE_STRIDE)
                           + ADDR_W'(CTRL_OFS);
                job_data   = img_l_q;
            end
            ST_SEND_B: begin
                job_valid  = 1'b1;
                job_target = TGT_RIGHT;
                job_addr   = ADDR_W'(voice_q) * ADDR_W'(VOICE_STRIDE)
                           + ADDR_W'(CTRL_OFS);
                job_data   = img_r_q;
            end
            ST_DONE: begin
                req_clr    = 1'b1;
                rescan_req = lead_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/psync_seq_chk.sv
`timescale 1ns/1ps
module psync_seq_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int MASK_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              job_valid,
    input logic              job_ack,
    input logic [1:0]        job_target,
    input logic [ADDR_W-1:0] job_addr,
    input logic [DATA_W-1:0] job_data,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_addr,
    input logic              req_clr,
    input logic              rescan_req,
    input logic              lead_q,
    input logic [MASK_W-1:0] mask_q
);
    logic [3:0] gap_q;
    logic       armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (job_valid && job_ack) begin
                gap_q   <= '0;
                armed_q <= 1'b1;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 4'd1;
            end
            if (req_clr) begin
                armed_q <= 1'b0;
            end
        end
    end

    assert_job_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && !job_ack) |=> (job_valid && $stable(job_addr)
                                     && $stable(job_data) && $stable(job_target)));

    assert_target_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> (job_target != 2'b00));

    assert_edit_scope_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !lead_q) |-> (((mask_q >> rf_addr) & MASK_W'(1)) != '0));

    assert_phase_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !job_valid);

    assert_clr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_clr |=> !req_clr);

    assert_rescan_lead_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rescan_req |-> (req_clr && lead_q));

    assert_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(job_valid) && !lead_q && armed_q) |-> (gap_q <= 4'd2));
endmodule

bind psync_seq psync_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .MASK_W(MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .job_valid (job_valid),
    .job_ack   (job_ack),
    .job_target(job_target),
    .job_addr  (job_addr),
    .job_data  (job_data),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .req_clr   (req_clr),
    .rescan_req(rescan_req),
    .lead_q    (lead_q),
    .mask_q    (mask_q)
);

// File: tb/psync_seq_bench.sv
`timescale 1ns/1ps
module psync_seq_bench;
    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] sync_req = '0;
    logic [1:0] engine_sel = '0;
    logic [7:0] phase_ofs = '0;
    logic       job_valid;
    logic [1:0] job_target;
    logic [4:0] job_addr;
    logic [7:0] job_data;
    logic       job_ack = 1'b0;
    logic [2:0] rf_addr;
    logic [7:0] rf_rdata;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic       req_clr;
    logic       rescan_req;

    psync_seq #(.CLK_PER_US(CPU)) u_psync_seq (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .engine_sel(engine_sel),
        .phase_ofs(phase_ofs), .job_valid(job_valid), .job_target(job_target),
        .job_addr(job_addr), .job_data(job_data), .job_ack(job_ack),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .req_clr(req_clr), .rescan_req(rescan_req)
    );

    always #2.5 clk = ~clk;

    logic [7:0] rf [6];
    assign rf_rdata = (rf_addr < 3'd6) ? rf[rf_addr] : 8'h00;
    int rf_writes = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we) begin
            rf[rf_addr] <= rf_wdata;
            rf_writes   <= rf_writes + 1;
        end
    end

    // Job responder and log
    int   lat = 0;
    int   wcnt = 0;
    bit   fresh = 1'b1;
    int   cur_start = 0;
    int   n_jobs = 0;
    int   lg_addr [32];
    int   lg_data [32];
    int   lg_tgt  [32];
    int   lg_st   [32];
    int   lg_hs   [32];
    int   clr_seen = 0;
    int   rescan_seen = 0;

    always @(negedge clk) begin
        if (req_clr) clr_seen = clr_seen + 1;
        if (rescan_req) rescan_seen = rescan_seen + 1;
        if (job_ack) begin
            job_ack = 1'b0;
            fresh   = 1'b1;
        end
        if (job_valid) begin
            if (fresh) begin
                cur_start = cyc;
                wcnt      = 0;
                fresh     = 1'b0;
            end
            if (wcnt >= lat) begin
                job_ack = 1'b1;
                if (n_jobs < 32) begin
                    lg_addr[n_jobs] = int'(job_addr);
                    lg_data[n_jobs] = int'(job_data);
                    lg_tgt[n_jobs]  = int'(job_target);
                    lg_st[n_jobs]   = cur_start;
                    lg_hs[n_jobs]   = cyc;
                end
                n_jobs = n_jobs + 1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_job(input int k, input int addr, input int data, input int tgt,
                           input string tag);
        chk(lg_addr[k] == addr, {tag, " addr"}, lg_addr[k], addr);
        chk(lg_data[k] == data, {tag, " data"}, lg_data[k], data);
        chk(lg_tgt[k] == tgt, {tag, " target"}, lg_tgt[k], tgt);
    endtask

    task automatic chk_gap(input int k, input int exp, input string tag);
        chk(lg_st[k+1] - lg_hs[k] == exp, tag, lg_st[k+1] - lg_hs[k], exp);
    endtask

    task automatic fill_rf(input logic [7:0] v);
        for (int i = 0; i < 6; i++) rf[i] = v;
    endtask

    task automatic run_seq(input logic [5:0] m, input logic [1:0] e, input logic [7:0] o,
                           input int l);
        @(negedge clk);
        n_jobs = 0; clr_seen = 0; rescan_seen = 0; lat = l;
        sync_req = m; engine_sel = e; phase_ofs = o;
        while (clr_seen == 0) begin
            @(negedge clk);
            #0.1;
        end
        sync_req = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_freq(input string tag);
        for (int v = 0; v < 3; v++) begin
            chk_job(2*v,   7*v,     8'hFF, 3, tag);
            chk_job(2*v+1, 7*v + 1, 8'hFF, 3, tag);
        end
    endtask

    task automatic t_reset_idle;
        @(negedge clk);
        chk(!job_valid && !rf_we, "R1 reset job/rf idle", {job_valid, rf_we}, 0);
        chk(!req_clr && !rescan_req, "R1 reset pulses low", {req_clr, rescan_req}, 0);
        repeat (20) @(negedge clk);
        chk(n_jobs == 0, "R1 zero mask no jobs", n_jobs, 0);
        chk(rf_writes == 0, "R1 zero mask no rf writes", rf_writes, 0);
        chk(clr_seen == 0, "R1 zero mask no clear", clr_seen, 0);
    endtask

    task automatic t_lead_split;
        fill_rf(8'h18);
        run_seq(6'b000101, 2'd0, 8'd0, 2);
        chk(n_jobs == 11, "R2 lead job count", n_jobs, 11);
        chk_freq("R3 lead split freq");
        chk(rf[0] == 8'h11 && rf[2] == 8'h11, "R4 left gate set", {rf[0], rf[2]}, 16'h1111);
        chk(rf[1] == 8'h10 && rf[3] == 8'h10 && rf[4] == 8'h10 && rf[5] == 8'h10,
            "R4 test cleared no gate", {rf[1], rf[3], rf[4], rf[5]}, 32'h10101010);
        chk_job(6, 4, 8'h11, 1, "R6 v1 left");
        chk_job(7, 4, 8'h10, 2, "R6 v1 right");
        chk_job(8, 11, 8'h10, 3, "R6 v2 dual");
        chk_job(9, 18, 8'h11, 1, "R6 v3 left");
        chk_job(10, 18, 8'h10, 2, "R6 v3 right");
        chk_gap(6, 1, "R10 split follow-on gap");
        chk_gap(7, 14*CPU + 3, "R7 gap after v1 offset 0");
        chk_gap(8, 14*CPU + 3, "R7 gap after v2 offset 0");
        chk(clr_seen == 1 && rescan_seen == 1, "R11 lead clear+rescan",
            clr_seen*16 + rescan_seen, 8'h11);
    endtask

    task automatic t_lead_all;
        fill_rf(8'h18);
        run_seq(6'b111111, 2'd0, 8'd100, 0);
        chk(n_jobs == 9, "R6 all-equal job count", n_jobs, 9);
        chk_freq("R3 lead all freq");
        chk_job(6, 4, 8'h11, 3, "R6 v1 dual");
        chk_job(7, 11, 8'h11, 3, "R6 v2 dual");
        chk_job(8, 18, 8'h11, 3, "R6 v3 dual");
        chk_gap(6, 114*CPU + 3, "R7 gap offset 100 v1");
        chk_gap(7, 114*CPU + 3, "R7 gap offset 100 v2");
    endtask

    task automatic t_lead_saturate;
        fill_rf(8'h18);
        run_seq(6'b001000, 2'd0, 8'd250, 1);
        chk(n_jobs == 10, "R8 job count", n_jobs, 10);
        chk_job(6, 4, 8'h10, 1, "R4 v1 left no gate");
        chk_job(7, 4, 8'h11, 2, "R4 v1 right gate");
        chk_gap(7, 255*CPU + 3, "R8 saturated gap v1");
        chk_gap(8, 255*CPU + 3, "R8 saturated gap v2");
        chk(rescan_seen == 1, "R11 lead rescan", rescan_seen, 1);
    endtask

    task automatic t_indiv_partial;
        int wr0;
        rf[0] = 8'h18; rf[1] = 8'h28; rf[2] = 8'h48;
        rf[3] = 8'h18; rf[4] = 8'h29; rf[5] = 8'h4A;
        wr0 = rf_writes;
        run_seq(6'b100010, 2'd2, 8'd0, 1);
        chk(rf_writes - wr0 == 2, "R5 only requested images written", rf_writes - wr0, 2);
        chk(rf[1] == 8'h21 && rf[5] == 8'h43, "R5 requested edited", {rf[1], rf[5]}, 16'h2143);
        chk(rf[0] == 8'h18 && rf[2] == 8'h48 && rf[3] == 8'h18 && rf[4] == 8'h29,
            "R5 others untouched", {rf[0], rf[2], rf[3], rf[4]}, 32'h18481829);
        chk(n_jobs == 5, "R2 individual no freq jobs", n_jobs, 5);
        chk_job(0, 4, 8'h18, 3, "R6 ind v1 dual");
        chk_job(1, 11, 8'h21, 1, "R6 ind v2 left");
        chk_job(2, 11, 8'h29, 2, "R6 ind v2 right");
        chk_job(3, 18, 8'h48, 1, "R6 ind v3 left");
        chk_job(4, 18, 8'h43, 2, "R6 ind v3 right");
        chk_gap(0, 3, "R9 ind gap v1");
        chk_gap(2, 3, "R9 ind gap v2");
        chk(clr_seen == 1 && rescan_seen == 0, "R11 ind clear no rescan",
            clr_seen*16 + rescan_seen, 8'h10);
    endtask

    task automatic t_indiv_engine3;
        fill_rf(8'h18);
        run_seq(6'b001000, 2'd3, 8'd50, 0);
        chk(n_jobs == 4, "R2 engine 3 job count", n_jobs, 4);
        chk_job(0, 4, 8'h18, 1, "R2 engine 3 first job ctrl");
        chk_job(1, 4, 8'h11, 2, "R5 engine 3 right v1");
        chk(rf[0] == 8'h18 && rf[3] == 8'h11, "R5 engine 3 images", {rf[0], rf[3]}, 16'h1811);
        chk(rescan_seen == 0, "R11 engine 3 no rescan", rescan_seen, 0);
    endtask

    initial begin
        fill_rf(8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_lead_split();
        t_lead_all();
        t_lead_saturate();
        t_indiv_partial();
        t_indiv_engine3();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule